// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking translation tables held in memory. A walk starts from a context table whose location is formed from a base register and a context number. It then descends through up to three levels of page tables, fetching one 32-bit entry per step over a single read/write memory port. An entry at level 1, 2 or 3 may end the walk as a leaf. Each leaf level gives a different page size: 16 MB, 256 KB or 4 KB.

When the walk succeeds, the block returns the physical address and a page-size code. When it fails, it returns a fault code that records the level that failed and the kind of failure. After a successful walk it may write the leaf entry back in place. The write sets the referenced flag and, for a store, the modified flag, and it is issued only when one of those flags actually changes. A pipeline or cache fill unit raises a request, waits for `done`, and uses the registered result. It does not check access permissions and it does not cache translations.

Top module: `twalk_top`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are 0 and `rsp_fault` is 0.
- R2: The first memory read of a walk is at address `ctx_base*16 + ctx_num*4`.
- R3: Each entry's low two bits give its kind: 0 invalid, 1 table pointer, 2 leaf, 3 reserved. For a table pointer at level L, the next read is at `{entry[31:2],6'b0} + 4*index`. The index is vaddr[31:24] for level 1, vaddr[23:18] for level 2 and vaddr[17:12] for level 3.
- R4: A leaf at level 1 gives `rsp_size`=2 (16 MB) with offset vaddr[23:0]. A leaf at level 2 gives size 1 (256 KB) with offset vaddr[17:0]. A leaf at level 3 gives size 0 (4 KB) with offset vaddr[11:0]. In each case `rsp_paddr = {entry[31:8],12'b0} + offset`.
- R5: The fault code carries the failing level (0 = context table, up to 3) in bits 9:8 and the fault type in bits 4:2; all its other bits are 0. A successful walk returns fault code 0. A faulting walk returns `rsp_paddr`=0 and `rsp_size`=0.
- R6: An invalid entry gives fault type 1.
- R7: Fault type 4 results from any of these: a reserved entry, a leaf in the context table, a table pointer at level 3, or an error response on a read. A read error wins over the returned data.
- R8: After a successful walk, the block computes a new leaf value: bit 5 (referenced) is set, and bit 6 (modified) is set too if the request was a write. If the new value differs from the old one, it is written to the leaf's address before `done`; otherwise no write is issued. A faulting walk never writes.
- R9: Only one memory access is outstanding at a time. `mem_req`, `mem_addr` and `mem_we` stay steady until `mem_ack`. `done` is a one-cycle pulse with `busy` low. A request raised while `busy` is ignored. A request raised in the cycle `done` is high is accepted.
- R10: An error response to the write-back does not change the walk's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store (sets modified flag) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_size | output | 2 | Page size code: 0 = 4 KB, 1 = 256 KB, 2 = 16 MB |
| rsp_fault | output | 10 | Level in 9:8, fault type in 4:2, 0 on success |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | PA_W | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory response strobe |
| mem_rdata | input | 32 | Entry read from memory |
| mem_err | input | 1 | Error response with `mem_ack` |
| ctx_base | input | 32 | Context table base (byte address / 16) |
| ctx_num | input | CTX_W | Context number |

## Verification
Two pairs of events can land in the same cycle. First, a read response can return a well-formed leaf entry together with an error flag. The bench stores a leaf at a level-1 slot and marks that address as erroring, and the walk must end with a level-1 translation fault rather than a mapping. Second, a new request can arrive in the very cycle that `done` pulses. The bench raises `req_valid` as soon as it sees `done` and expects the following walk's first read at the new context pointer with no lost or duplicated result. A reference walker in the bench predicts every memory access and result from the same table contents and compares them as they appear.

// File: rtl/twalk_pkg.sv
package twalk_pkg;
  localparam int ENT_W   = 32;
  localparam int REF_POS = 5;
  localparam int MOD_POS = 6;
  localparam int PPN_LSB = 8;
  localparam int FC_W    = 10;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;

  typedef enum logic [1:0] {
    EK_INVALID = 2'd0,
    EK_TABLE   = 2'd1,
    EK_LEAF    = 2'd2,
    EK_RSVD    = 2'd3
  } ekind_e;

  typedef enum logic [1:0] {
    OC_DESCEND = 2'd0,
    OC_LEAF    = 2'd1,
    OC_FAULT   = 2'd2
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WBACK = 2'd2
  } wstate_e;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_256K = 2'd1,
    PG_16M  = 2'd2
  } pgsize_e;
endpackage

// File: rtl/twalk_ptr_calc.sv
// Forms the context-table pointer and the next-level table pointer.
module twalk_ptr_calc
  import twalk_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic [31:0]      ctx_base,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [19:0]      va_hi,     // vaddr[31:12]
  input  logic [29:0]      tbl_ptr,   // entry[31:2]
  input  logic [1:0]       next_lvl,
  output logic [PA_W-1:0]  root_ptr,
  output logic [PA_W-1:0]  next_ptr
);
  localparam int L1_IDX_W = 8;
  localparam int LN_IDX_W = 6;
  localparam int PAD_W    = L1_IDX_W - LN_IDX_W;

  logic [L1_IDX_W-1:0] idx;

  always_comb begin
    unique case (next_lvl)
      2'd1:    idx = va_hi[19:12];
      2'd2:    idx = {{PAD_W{1'b0}}, va_hi[11:6]};
      2'd3:    idx = {{PAD_W{1'b0}}, va_hi[5:0]};
      default: idx = '0;
    endcase
  end

  assign root_ptr = PA_W'({ctx_base, 4'b0}) + PA_W'({ctx_num, 2'b0});
  assign next_ptr = PA_W'({tbl_ptr, 6'b0}) + PA_W'({idx, 2'b0});
endmodule

// File: rtl/twalk_entry_decode.sv
// Classifies a fetched entry and prepares the write-back value.
module twalk_entry_decode
  import twalk_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [1:0]       lvl,
  input  logic             bus_err,
  input  logic             is_write,
  output outcome_e         outcome,
  output logic [2:0]       ftype,
  output logic [ENT_W-1:0] wb_entry,
  output logic             wb_needed
);
  localparam logic [1:0] LAST_LVL = 2'd3;
  localparam logic [1:0] CTX_LVL  = 2'd0;

  ekind_e kind;

  always_comb begin
    kind    = ekind_e'(entry[1:0]);
    outcome = OC_FAULT;
    ftype   = FT_XLATE;
    if (!bus_err) begin
      unique case (kind)
        EK_INVALID: ftype = FT_INVALID;
        EK_TABLE:   if (lvl != LAST_LVL) outcome = OC_DESCEND;
        EK_LEAF:    if (lvl != CTX_LVL) outcome = OC_LEAF;
        default:    ftype = FT_XLATE;
      endcase
    end
  end

  always_comb begin
    wb_entry = entry;
    wb_entry[REF_POS] = 1'b1;
    if (is_write) wb_entry[MOD_POS] = 1'b1;
    wb_needed = (wb_entry != entry);
  end
endmodule

// File: rtl/twalk_leaf_map.sv
// Builds the physical address and size code from a leaf entry.
module twalk_leaf_map
  import twalk_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [23:0]     ppn,
  input  logic [23:0]     va_lo,     // vaddr[23:0]
  input  logic [1:0]      lvl,
  output logic [PA_W-1:0] paddr,
  output pgsize_e         size
);
  localparam int OFF_W = 24;

  logic [OFF_W-1:0] off;

  always_comb begin
    unique case (lvl)
      2'd1: begin
        off  = va_lo;
        size = PG_16M;
      end
      2'd2: begin
        off  = {6'b0, va_lo[17:0]};
        size = PG_256K;
      end
      default: begin
        off  = {12'b0, va_lo[11:0]};
        size = PG_4K;
      end
    endcase
  end

  assign paddr = PA_W'({ppn, 12'b0}) + PA_W'(off);
endmodule

// File: rtl/twalk_top.sv
module twalk_top
  import twalk_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic             req_write,
  output logic             busy,
  output logic             done,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_size,
  output logic [FC_W-1:0]  rsp_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata,
  input  logic             mem_err,
  input  logic [31:0]      ctx_base,
  input  logic [CTX_W-1:0] ctx_num
);
  wstate_e          state;
  logic [1:0]       lvl;
  logic [31:0]      va_q;
  logic             wr_q;
  logic [PA_W-1:0]  pend_paddr;
  pgsize_e          pend_size;

  logic [PA_W-1:0]  root_ptr, next_ptr, leaf_paddr;
  pgsize_e          leaf_size;
  outcome_e         outcome;
  logic [2:0]       ftype;
  logic [ENT_W-1:0] wb_entry;
  logic             wb_needed;

  twalk_ptr_calc #(.PA_W(PA_W), .CTX_W(CTX_W)) ptr_i (
    .ctx_base (ctx_base),
    .ctx_num  (ctx_num),
    .va_hi    (va_q[31:12]),
    .tbl_ptr  (mem_rdata[31:2]),
    .next_lvl (lvl + 2'd1),
    .root_ptr (root_ptr),
    .next_ptr (next_ptr)
  );

  twalk_entry_decode dec_i (
    .entry     (mem_rdata),
    .lvl       (lvl),
    .bus_err   (mem_err),
    .is_write  (wr_q),
    .outcome   (outcome),
    .ftype     (ftype),
    .wb_entry  (wb_entry),
    .wb_needed (wb_needed)
  );

  twalk_leaf_map #(.PA_W(PA_W)) map_i (
    .ppn   (mem_rdata[31:PPN_LSB]),
    .va_lo (va_q[23:0]),
    .lvl   (lvl),
    .paddr (leaf_paddr),
    .size  (leaf_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lvl        <= '0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      pend_paddr <= '0;
      pend_size  <= PG_4K;
      busy       <= 1'b0;
      done       <= 1'b0;
      rsp_paddr  <= '0;
      rsp_size   <= '0;
      rsp_fault  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            lvl      <= '0;
            mem_addr <= root_ptr;
            mem_we   <= 1'b0;
            mem_req  <= 1'b1;
            busy     <= 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            unique case (outcome)
              OC_DESCEND: begin
                lvl      <= lvl + 2'd1;
                mem_addr <= next_ptr;
              end
              OC_LEAF: begin
                if (wb_needed) begin
                  mem_we     <= 1'b1;
                  mem_wdata  <= wb_entry;
                  pend_paddr <= leaf_paddr;
                  pend_size  <= leaf_size;
                  state      <= ST_WBACK;
                end else begin
                  mem_req   <= 1'b0;
                  busy      <= 1'b0;
                  done      <= 1'b1;
                  rsp_paddr <= leaf_paddr;
                  rsp_size  <= leaf_size;
                  rsp_fault <= '0;
                  state     <= ST_IDLE;
                end
              end
              default: begin
                mem_req   <= 1'b0;
                busy      <= 1'b0;
                done      <= 1'b1;
                rsp_paddr <= '0;
                rsp_size  <= '0;
                rsp_fault <= {lvl, 3'b000, ftype, 2'b00};
                state     <= ST_IDLE;
              end
            endcase
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b1;
            rsp_paddr <= pend_paddr;
            rsp_size  <= pend_size;
            rsp_fault <= '0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done && !mem_req && !mem_we && rsp_fault == '0));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8
  wb_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[REF_POS]);

  // R8
  wb_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && wr_q) |-> mem_wdata[MOD_POS]);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_fault != '0) |-> (rsp_paddr == '0 && rsp_size == '0
                                   && rsp_fault[7:5] == 3'b000 && rsp_fault[1:0] == 2'b00));
endmodule

// File: tb/twalk_top_tb_top.sv
module twalk_top_tb_top;
  localparam int PA_W  = 36;
  localparam int CTX_W = 8;

  typedef struct packed {
    logic [35:0] a;
    logic        we;
    logic [31:0] d;
  } acc_t;

  typedef struct packed {
    logic [35:0] pa;
    logic [1:0]  sz;
    logic [9:0]  fc;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic busy, done, mem_req, mem_we;
  logic [PA_W-1:0] rsp_paddr, mem_addr;
  logic [1:0] rsp_size;
  logic [9:0] rsp_fault;
  logic [31:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic mem_err = 1'b0;
  logic [31:0] ctx_base = 32'h0000_1000;
  logic [CTX_W-1:0] ctx_num = 8'd3;

  always #5 clk = ~clk;

  twalk_top #(.PA_W(PA_W), .CTX_W(CTX_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .busy(busy), .done(done), .rsp_paddr(rsp_paddr),
    .rsp_size(rsp_size), .rsp_fault(rsp_fault), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .ctx_base(ctx_base), .ctx_num(ctx_num)
  );

  logic [31:0] mem_arr [logic [35:0]];
  bit          rd_err  [logic [35:0]];
  acc_t exp_acc[$];
  res_t exp_res[$];
  int n_cmp = 0;
  int n_bad = 0;
  int lat = 1;
  int waitc = 0;
  bit logged = 0;
  bit wr_err_mode = 0;
  bit finished = 0;
  string cur_tag = "R1";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [35:0] a);
    return mem_arr.exists(a) ? mem_arr[a] : 32'h0;
  endfunction

  // Reference walker: predicts accesses and result from the table contents.
  task automatic predict(input logic [31:0] va, input bit wr);
    longint unsigned ptr;
    int lv;
    bit fin;
    res_t r;
    acc_t x;
    logic [31:0] e, ne;
    longint unsigned off;
    ptr = (longint'(ctx_base) << 4) + (longint'(ctx_num) << 2);
    lv = 0;
    fin = 0;
    r = '0;
    while (!fin) begin
      x.a = ptr[35:0]; x.we = 1'b0; x.d = '0;
      exp_acc.push_back(x);
      fin = 1;
      if (rd_err.exists(ptr[35:0])) begin
        r.fc = 10'((lv << 8) | (4 << 2));
      end else begin
        e = rd_mem(ptr[35:0]);
        case (e[1:0])
          2'd0: r.fc = 10'((lv << 8) | (1 << 2));
          2'd3: r.fc = 10'((lv << 8) | (4 << 2));
          2'd1: begin
            if (lv == 3) r.fc = 10'((lv << 8) | (4 << 2));
            else begin
              lv++;
              off = (lv == 1) ? ((va >> 24) & 32'hff) :
                    (lv == 2) ? ((va >> 18) & 32'h3f) : ((va >> 12) & 32'h3f);
              ptr = ((longint'(e) & ~64'd3) << 4) + off * 4;
              fin = 0;
            end
          end
          default: begin
            if (lv == 0) r.fc = 10'(4 << 2);
            else begin
              off = (lv == 1) ? (va & 32'hffffff) :
                    (lv == 2) ? (va & 32'h3ffff) : (va & 32'hfff);
              r.pa = 36'(((longint'(e) >> 8) << 12) + off);
              r.sz = (lv == 1) ? 2'd2 : (lv == 2) ? 2'd1 : 2'd0;
              ne = e | 32'h20 | (wr ? 32'h40 : 32'h0);
              if (ne != e) begin
                x.a = ptr[35:0]; x.we = 1'b1; x.d = ne;
                exp_acc.push_back(x);
              end
            end
          end
        endcase
      end
    end
    exp_res.push_back(r);
  endtask

  // Memory responder and monitor, all at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        check(!(done && busy), "R9", "done with busy", {62'b0, done, busy}, 64'h2);
        if (done) begin
          if (exp_res.size() == 0) begin
            check(0, "R9", "unexpected done", 64'h1, 64'h0);
          end else begin
            res_t r;
            r = exp_res.pop_front();
            check(rsp_paddr == r.pa, cur_tag, "paddr", 64'(rsp_paddr), 64'(r.pa));
            check(rsp_size == r.sz, cur_tag, "size", 64'(rsp_size), 64'(r.sz));
            check(rsp_fault == r.fc, cur_tag, "fault", 64'(rsp_fault), 64'(r.fc));
          end
        end
        if (mem_ack) begin
          mem_ack = 1'b0;
          mem_err = 1'b0;
        end
        if (mem_req) begin
          if (!logged) begin
            logged = 1;
            if (exp_acc.size() == 0) begin
              check(0, cur_tag, "unexpected access", 64'(mem_addr), 64'h0);
            end else begin
              acc_t x;
              x = exp_acc.pop_front();
              check(mem_addr == x.a, cur_tag, "access addr", 64'(mem_addr), 64'(x.a));
              check(mem_we == x.we, cur_tag, "access we", 64'(mem_we), 64'(x.we));
              if (x.we)
                check(mem_wdata == x.d, cur_tag, "write data", 64'(mem_wdata), 64'(x.d));
            end
          end
          if (waitc >= lat) begin
            mem_ack = 1'b1;
            if (mem_we) begin
              if (wr_err_mode) mem_err = 1'b1;
              else mem_arr[mem_addr] = mem_wdata;
            end else begin
              mem_rdata = rd_mem(mem_addr);
              mem_err = rd_err.exists(mem_addr);
            end
            waitc = 0;
            logged = 0;
          end else begin
            waitc++;
          end
        end
      end
    end
  end

  task automatic issue(input logic [31:0] va, input bit wr);
    predict(va, wr);
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input string tag);
    cur_tag = tag;
    issue(va, wr);
    while (exp_res.size() != 0) @(negedge clk);
    @(negedge clk);
    check(exp_acc.size() == 0, tag, "pending accesses", 64'(exp_acc.size()), 64'h0);
  endtask

  initial begin
    // context table at 0x10000, level tables at 0x20000/0x30000/0x40000
    mem_arr[36'h1000C] = 32'h0000_2001;
    mem_arr[36'h20048] = 32'h0000_3001;
    mem_arr[36'h30034] = 32'h0000_4001;
    mem_arr[36'h40014] = 32'h0ABC_DE02;   // 4 KB leaf
    mem_arr[36'h300A0] = 32'h0000_5502;   // 256 KB leaf
    mem_arr[36'h201DC] = 32'h0080_0062;   // 16 MB leaf, flags already set
    mem_arr[36'h200CC] = 32'h0000_0003;   // reserved
    mem_arr[36'h4001C] = 32'h0000_4001;   // table pointer at level 3
    mem_arr[36'h20154] = 32'h0012_3402;   // leaf returned with error
    rd_err[36'h20154]  = 1'b1;
    mem_arr[36'h10014] = 32'h0099_9902;   // leaf in context table

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !mem_req && !mem_we, "R1", "idle after reset",
          {60'b0, busy, done, mem_req, mem_we}, 64'h0);
    check(rsp_fault == '0, "R1", "fault after reset", 64'(rsp_fault), 64'h0);

    lat = 1; walk(32'h1234_5678, 1'b0, "R2");   // 4 KB leaf, R8 sets referenced
    lat = 2; walk(32'h1234_5678, 1'b0, "R8");   // already referenced: no write
    wr_err_mode = 1;
    walk(32'h1234_5678, 1'b1, "R10");           // write-back errors, result stands
    wr_err_mode = 0;
    lat = 0; walk(32'h1234_5678, 1'b1, "R8");   // sets modified
    walk(32'h1234_5678, 1'b1, "R8");            // nothing changes
    lat = 0; walk(32'h12A0_1234, 1'b1, "R4");   // 256 KB leaf
    lat = 3; walk(32'h7700_0ABC, 1'b1, "R4");   // 16 MB leaf, no write needed
    lat = 1; walk(32'h12FC_0000, 1'b0, "R6");   // invalid at level 2
    walk(32'h3300_0000, 1'b0, "R7");            // reserved at level 1
    walk(32'h1234_7000, 1'b0, "R7");            // table at level 3
    walk(32'h5500_0000, 1'b0, "R7");            // read error with leaf data
    walk(32'h1234_5678, 1'b0, "R3");            // pointer chain, idle interval
    ctx_num = 8'd5;
    walk(32'h1234_5678, 1'b0, "R7");            // leaf in context table
    ctx_num = 8'd6;
    walk(32'h1234_5678, 1'b0, "R6");            // invalid context entry
    ctx_num = 8'd3;

    // R9: request raised while busy is ignored
    cur_tag = "R9";
    lat = 3;
    issue(32'h12A0_0000, 1'b0);
    req_vaddr = 32'h3300_0000;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_res.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(!busy, "R9", "busy after ignored request", 64'(busy), 64'h0);
    check(exp_acc.size() == 0, "R9", "pending accesses", 64'(exp_acc.size()), 64'h0);

    // R9: request accepted in the done cycle
    lat = 1;
    issue(32'h7700_0000, 1'b0);
    while (!done) @(negedge clk);
    predict(32'h12FC_0000, 1'b0);
    req_vaddr = 32'h12FC_0000;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R9", "accepted in done cycle", 64'(busy), 64'h1);
    while (exp_res.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_acc.size() == 0, "R9", "pending accesses", 64'(exp_acc.size()), 64'h0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule